// File: doc/BRIEF.md
# Block Sum-of-Absolute-Differences Accumulator

This block measures how far apart two rows of pixels are. Each input row is a 128-bit vector that holds sixteen unsigned 8-bit samples. The block takes the difference in every lane, makes it positive, and adds the sixteen results into one number. It then adds that row total into a running block total. A block is a run of rows marked with a first-row flag and a last-row flag. When the last row has been added, the block raises a one-cycle done pulse and shows the block total. A typical use compares a predicted block with an original block, one row per accepted transfer.

The lane totals can be reduced in one of two ways, chosen per row by a mode input:

- **Single-step full sum.** All lanes are added in one combinational tree. The row is finished one cycle after it is accepted.
- **Pairwise reduction.** Each step adds only two neighbouring elements. Four steps are needed to reduce sixteen lanes to one value, so the row finishes four cycles after it is accepted. The block reports busy while the reduction is running.

Top module: `sad_block_top`

## Requirements
- R1: Every byte lane `i`, using bits `[8*i+7:8*i]` of each vector, gives `|a-b|` with both bytes read as unsigned. The result is the same whichever operand is larger, and it is zero when the two bytes are equal.
- R2: With `pairMode` low, an accepted row marked last makes `sadDone` high, with `blockSad` equal to the block total, in the cycle right after the accepting clock edge.
- R3: With `pairMode` high, an accepted row makes `busy` high for the next three cycles. `sadDone` (if the row is marked last) and the updated total appear in the fourth cycle after acceptance, and `busy` is low again in that cycle.
- R4: A row presented with `inVld` high while `busy` is high is not accepted. Its data and its flags have no effect on the block total or on `sadDone`.
- R5: A row accepted with `firstRow` high starts a new block. Any earlier total is discarded before this row's sum is added.
- R6: Rows accepted without `firstRow` add their sums to the running total. `sadDone` stays low after rows that are not marked last.
- R7: While reset (`rst_n` low, active low) is applied, `sadDone` and `busy` are low and `blockSad` is zero.
- R8: The 16-bit default total holds a full 16-row block of maximum differences, giving exactly 65280.
- R9: Both modes give the same row sum for the same data. The mode may change from row to row within one block.
- R10: When no row is accepted and no reduction finishes, `blockSad` holds its value and `sadDone` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inVld | input | 1 | Row present; the row is taken when `busy` is low |
| pairMode | input | 1 | 1 = pairwise reduction, 0 = single-step full sum |
| firstRow | input | 1 | Row starts a new block |
| lastRow | input | 1 | Row ends the block |
| vecA | input | 128 | Sixteen unsigned pixels, lane i at bits [8i+7:8i] |
| vecB | input | 128 | Sixteen unsigned pixels compared against vecA |
| busy | output | 1 | Pairwise reduction in progress; inputs ignored |
| sadDone | output | 1 | One-cycle pulse after the last row is added |
| blockSad | output | 16 | Running or final block total |

## Verification
The hardest case to reach from the ports is a row offered while a pairwise reduction is still in flight. The bench covers it by holding `inVld` high through the whole busy window, with extreme pixel values and both block flags set. It then checks that the finished total reflects only the first row.

The full-scale case is a sixteen-row block of 255-versus-0 rows with the mode alternating each row. This drives the total to exactly 65280 and also mixes both reduction paths inside one block.

Lanes with unequal values in both orders are run through both modes and compared against a lane-by-lane model in the bench.

// File: rtl/sad_pkg.sv
package sad_pkg;

  // States of the pairwise reduction sequencer
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_REDUCE = 1'b1
  } sadState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadFull;    // add single-step row sum this edge
    logic loadPair;    // capture first pairwise level
    logic stepPair;    // apply one more pairwise level
    logic finishPair;  // last pairwise add, into accumulator
    logic clearAcc;    // drop the old total before adding
    logic flagDone;    // raise done after this update
  } sadStrobe_t;

endpackage

// File: rtl/sad_ctrl.sv
module sad_ctrl
  import sad_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inVld,
  input  logic       pairMode,
  input  logic       firstRow,
  input  logic       lastRow,
  output logic       busy,
  output sadStrobe_t str
);

  localparam int STEPS = $clog2(LANES);
  localparam int CNT_W = (STEPS > 2) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STEPS - 1);

  sadState_t       stateQ;
  logic [CNT_W-1:0] cntQ;
  logic            firstQ;
  logic            lastQ;
  logic            accept;

  assign busy   = (stateQ == ST_REDUCE);
  assign accept = inVld && !busy;

  always_comb begin
    str            = '0;
    str.loadFull   = accept && !pairMode;
    str.loadPair   = accept && pairMode;
    str.stepPair   = busy && (cntQ != LAST_CNT);
    str.finishPair = busy && (cntQ == LAST_CNT);
    str.clearAcc   = (str.loadFull && firstRow) || (str.finishPair && firstQ);
    str.flagDone   = (str.loadFull && lastRow) || (str.finishPair && lastQ);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      firstQ <= 1'b0;
      lastQ  <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (str.loadPair) begin
            stateQ <= ST_REDUCE;
            cntQ   <= CNT_W'(1);
            firstQ <= firstRow;
            lastQ  <= lastRow;
          end
        end
        default: begin
          if (cntQ == LAST_CNT) begin
            stateQ <= ST_IDLE;
            cntQ   <= '0;
          end else begin
            cntQ <= cntQ + CNT_W'(1);
          end
        end
      endcase
    end
  end

  // R3
  finish_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    str.finishPair |=> !busy);

  // R4
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && inVld |=> $stable(firstQ) && $stable(lastQ));

endmodule

// File: rtl/sad_datapath.sv
module sad_datapath
  import sad_pkg::*;
#(
  parameter int LANES = 16,
  parameter int PIX_W = 8,
  parameter int ACC_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES*PIX_W-1:0] vecA,
  input  logic [LANES*PIX_W-1:0] vecB,
  input  sadStrobe_t             str,
  output logic                   sadDone,
  output logic [ACC_W-1:0]       blockSad
);

  localparam int HALF = LANES / 2;

  logic [PIX_W-1:0] absDiff [LANES];
  logic [ACC_W-1:0] pairQ   [HALF];
  logic [ACC_W-1:0] pairNxt [HALF];
  logic [ACC_W-1:0] fullSum;
  logic [ACC_W-1:0] finishSum;
  logic [ACC_W-1:0] accBase;
  logic [ACC_W-1:0] accQ;
  logic             doneQ;

  // per-lane unsigned absolute difference
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [PIX_W-1:0] pa;
    logic [PIX_W-1:0] pb;
    assign pa = vecA[i*PIX_W +: PIX_W];
    assign pb = vecB[i*PIX_W +: PIX_W];
    assign absDiff[i] = (pa >= pb) ? (pa - pb) : (pb - pa);

    always_comb begin
      if (rst_n) begin
        // R1
        lane_zero_chk: assert ((pa == pb) == (absDiff[i] == '0));
      end
    end
  end

  // single-step horizontal sum over every lane
  always_comb begin
    fullSum = '0;
    for (int i = 0; i < LANES; i++) begin
      fullSum = fullSum + ACC_W'(absDiff[i]);
    end
  end

  // next level of the pairwise reduction
  for (genvar i = 0; i < HALF; i++) begin : g_pair
    if (i < HALF / 2) begin : g_live
      always_comb begin
        if (str.loadPair) pairNxt[i] = ACC_W'(absDiff[2*i]) + ACC_W'(absDiff[2*i+1]);
        else              pairNxt[i] = pairQ[2*i] + pairQ[2*i+1];
      end
    end else begin : g_tail
      always_comb begin
        if (str.loadPair) pairNxt[i] = ACC_W'(absDiff[2*i]) + ACC_W'(absDiff[2*i+1]);
        else              pairNxt[i] = '0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) pairQ[i] <= '0;
      else if (str.loadPair || str.stepPair) pairQ[i] <= pairNxt[i];
    end
  end

  assign finishSum = pairQ[0] + pairQ[1];
  assign accBase   = str.clearAcc ? '0 : accQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= str.flagDone;
      if (str.loadFull)        accQ <= accBase + fullSum;
      else if (str.finishPair) accQ <= accBase + finishSum;
    end
  end

  assign sadDone  = doneQ;
  assign blockSad = accQ;

  // R10
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(str.loadFull || str.finishPair) |=> $stable(accQ));

endmodule

// File: rtl/sad_block_top.sv
module sad_block_top
  import sad_pkg::*;
#(
  parameter int LANES = 16,
  parameter int PIX_W = 8,
  parameter int ACC_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inVld,
  input  logic                   pairMode,
  input  logic                   firstRow,
  input  logic                   lastRow,
  input  logic [LANES*PIX_W-1:0] vecA,
  input  logic [LANES*PIX_W-1:0] vecB,
  output logic                   busy,
  output logic                   sadDone,
  output logic [ACC_W-1:0]       blockSad
);

  sadStrobe_t str;

  sad_ctrl #(.LANES(LANES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inVld    (inVld),
    .pairMode (pairMode),
    .firstRow (firstRow),
    .lastRow  (lastRow),
    .busy     (busy),
    .str      (str)
  );

  sad_datapath #(.LANES(LANES), .PIX_W(PIX_W), .ACC_W(ACC_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .vecA     (vecA),
    .vecB     (vecB),
    .str      (str),
    .sadDone  (sadDone),
    .blockSad (blockSad)
  );

  // R2
  full_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inVld && !busy && !pairMode && lastRow |=> sadDone);

  // R3
  pair_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inVld && !busy && pairMode |=> busy && !sadDone);

endmodule

// File: tb/sad_block_top_tb.sv
module sad_block_top_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         inVld;
  logic         pairMode;
  logic         firstRow;
  logic         lastRow;
  logic [127:0] vecA;
  logic [127:0] vecB;
  logic         busy;
  logic         sadDone;
  logic [15:0]  blockSad;

  int  total = 0;
  int  bad   = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  sad_block_top u_dut (
    .clk(clk), .rst_n(rst_n), .inVld(inVld), .pairMode(pairMode),
    .firstRow(firstRow), .lastRow(lastRow), .vecA(vecA), .vecB(vecB),
    .busy(busy), .sadDone(sadDone), .blockSad(blockSad)
  );

  typedef struct packed {
    logic [7:0]  a;
    logic [7:0]  b;
    logic        pair;
    logic        first;
    logic        last;
    logic [15:0] exp;
  } vec_t;

  // every lane carries the same byte, so sum = 16*|a-b|
  localparam vec_t TBL [6] = '{
    '{8'd10,  8'd3,   1'b0, 1'b1, 1'b1, 16'd112},
    '{8'd3,   8'd10,  1'b1, 1'b1, 1'b1, 16'd112},
    '{8'd200, 8'd0,   1'b0, 1'b1, 1'b0, 16'd3200},
    '{8'd0,   8'd255, 1'b1, 1'b0, 1'b0, 16'd7280},
    '{8'd50,  8'd50,  1'b0, 1'b0, 1'b1, 16'd7280},
    '{8'd1,   8'd2,   1'b1, 1'b1, 1'b1, 16'd16}
  };

  function automatic logic [127:0] fill(input logic [7:0] v);
    return {16{v}};
  endfunction

  function automatic int refSad(input logic [127:0] a, input logic [127:0] b);
    int s = 0;
    for (int i = 0; i < 16; i++) begin
      int x = int'(a[i*8 +: 8]);
      int y = int'(b[i*8 +: 8]);
      s += (x > y) ? (x - y) : (y - x);
    end
    return s;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // drives one row at a negedge and checks its completion timing
  task automatic runRow(input logic [127:0] a, input logic [127:0] b,
                        input logic pair, input logic first, input logic last,
                        input int exp, input string tag);
    @(negedge clk);
    vecA = a; vecB = b; pairMode = pair; firstRow = first; lastRow = last;
    inVld = 1'b1;
    @(negedge clk);
    inVld = 1'b0;
    if (pair) begin
      for (int k = 0; k < 3; k++) begin
        chk({tag, " R3 busy during reduction"}, int'(busy), 1);
        chk({tag, " R3 no early done"}, int'(sadDone), 0);
        @(negedge clk);
      end
      chk({tag, " R3 busy released"}, int'(busy), 0);
    end
    chk({tag, " R2/R6 done flag"}, int'(sadDone), int'(last));
    if (last) chk({tag, " R2/R3 block total"}, int'(blockSad), exp);
  endtask

  initial begin
    rst_n = 1'b0; inVld = 1'b0; pairMode = 1'b0; firstRow = 1'b0;
    lastRow = 1'b0; vecA = '0; vecB = '0;
    repeat (3) @(negedge clk);
    chk("R7 reset done", int'(sadDone), 0);
    chk("R7 reset busy", int'(busy), 0);
    chk("R7 reset total", int'(blockSad), 0);
    rst_n = 1'b1;

    // table walk: R1 order, R5 clear, R6 accumulation, R9 mixed modes
    for (int i = 0; i < 6; i++) begin
      runRow(fill(TBL[i].a), fill(TBL[i].b), TBL[i].pair, TBL[i].first,
             TBL[i].last, int'(TBL[i].exp), $sformatf("R5/R6 row%0d", i));
    end

    // R1 mixed lanes with both orderings, R9 both modes agree
    begin
      logic [127:0] ma, mb;
      for (int i = 0; i < 16; i++) begin
        ma[i*8 +: 8] = 8'(i * 17);
        mb[i*8 +: 8] = 8'(255 - i * 13);
      end
      runRow(ma, mb, 1'b0, 1'b1, 1'b1, refSad(ma, mb), "R1 R9 full mixed");
      runRow(ma, mb, 1'b1, 1'b1, 1'b1, refSad(ma, mb), "R1 R9 pair mixed");
      runRow(mb, ma, 1'b1, 1'b1, 1'b1, refSad(ma, mb), "R1 swapped");
    end

    // R4 rows offered while busy are ignored
    @(negedge clk);
    vecA = fill(8'd9); vecB = fill(8'd4); pairMode = 1'b1;
    firstRow = 1'b1; lastRow = 1'b1; inVld = 1'b1;
    @(negedge clk);
    vecA = fill(8'd255); vecB = fill(8'd0); pairMode = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R4 busy hold", int'(busy), 1);
      @(negedge clk);
    end
    inVld = 1'b0;
    chk("R4 done after ignored rows", int'(sadDone), 1);
    chk("R4 total excludes ignored rows", int'(blockSad), 80);
    @(negedge clk);
    chk("R4 no extra done", int'(sadDone), 0);
    chk("R4 total unchanged", int'(blockSad), 80);

    // R8 full-scale block, alternating modes (R9)
    for (int r = 0; r < 16; r++) begin
      runRow(fill(8'd255), fill(8'd0), 1'(r % 2), (r == 0), (r == 15),
             65280, "R8 R9 full scale");
    end

    // R10 idle cycles: nothing changes
    vecA = fill(8'd77); vecB = fill(8'd1); firstRow = 1'b1; lastRow = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R10 idle total", int'(blockSad), 65280);
      chk("R10 idle done", int'(sadDone), 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule